// File: doc/BRIEF.md
# Dynamic Loss Scale Controller

This block holds the global loss-scale factor for mixed-precision training hardware. Gradient words in half precision stream in, each with a valid strobe and a flag marking the final word of a training step. The block scans each valid word for a non-finite value (infinity or NaN). When a step ends, it pulses a completion flag and a skip flag. The skip flag tells the optimizer to drop that update because the gradients of the step overflowed.

The scale is stored as a signed power-of-two exponent, so every scale change is an exponent adjustment. If a step overflows, the exponent is cut by a fixed backoff amount and the run of clean steps starts again. If a programmable number of clean steps follow one another, the exponent rises by one. Both moves saturate at parameter limits. A separate combinational port divides any half-precision word by the current scale. This port handles subnormals, passes non-finite values through unchanged and flags results that grow past the largest finite half-precision value.

Top module: `loss_scale_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `scale_exp` loads `cfg_init_exp` clamped to [MIN_EXP, MAX_EXP], the clean-step count clears, no overflow is pending, and `step_done` and `step_skip` are low.
- R2: A word counts as non-finite when `grad_valid` is high and its exponent field, bits 14:10 of `grad_data`, is 5'b11111. One such word anywhere in a step makes the whole step overflowed. Words presented with `grad_valid` low are ignored.
- R3: `step_done` is high for exactly the one cycle after the edge that captures a word with `grad_valid` and `grad_last` both high. `step_skip` is high in that same cycle if and only if the step overflowed, and it is low at all other times.
- R4: An overflowed step lowers `scale_exp` by BACKOFF, saturating at MIN_EXP, and restarts the clean-step run. The new value is visible in the `step_done` cycle.
- R5: A clean step that completes a run of `cfg_grow_steps` consecutive clean steps raises `scale_exp` by one, saturating at MAX_EXP, and restarts the run. A value of 0 behaves as 1.
- R6: `scale_exp` changes only at the edge that ends a step or under reset. It is constant between steps and across the non-final words of a step.
- R7: For a finite nonzero `unscale_in`, `unscale_out` is the input multiplied by 2^-`scale_exp`, truncated toward zero, in normal or subnormal encoding as the magnitude requires. A zero input yields zero with the same sign.
- R8: If the exact unscaled magnitude exceeds 65504, `unscale_out` is infinity with the input's sign and `unscale_ovf` is high. Otherwise `unscale_ovf` is low.
- R9: An infinity or NaN on `unscale_in` (exponent field all ones) appears unchanged on `unscale_out`, with `unscale_ovf` low.
- R10: A finite unscaled magnitude below 2^-24 becomes a zero of the input's sign. A finite input never produces a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_init_exp | input | EXP_W | Signed scale exponent loaded at reset |
| cfg_grow_steps | input | CNT_W | Clean steps required before each growth |
| grad_valid | input | 1 | Gradient word valid |
| grad_last | input | 1 | Final word of the current step |
| grad_data | input | 16 | Half-precision gradient word |
| step_done | output | 1 | One-cycle pulse after the final word of a step |
| step_skip | output | 1 | Skip the optimizer update for the finished step |
| scale_exp | output | EXP_W | Current signed scale exponent |
| unscale_in | input | 16 | Half-precision word to unscale |
| unscale_out | output | 16 | Input divided by 2^scale_exp |
| unscale_ovf | output | 1 | Unscaled result exceeded the finite range |

## Verification
The bench builds the block with EXP_W=6, MIN_EXP=-4, MAX_EXP=12, CNT_W=4 and BACKOFF=1. The narrow exponent span lets a few dozen steps reach both saturation limits. The negative lower limit means that unscaling sometimes multiplies, so overflow to infinity can be reached. The 4-bit counter makes the largest growth interval (15) short enough to run in full. At five scale exponents across that span, every one of the 65536 input codes is swept through the unscale port and compared against an arithmetic model computed in real numbers. Separately, every value of the exponent field is sent as a gradient word.

// File: rtl/loss_scale_ctrl.sv
module loss_scale_ctrl #(
  parameter int EXP_W   = 6,
  parameter int MIN_EXP = 0,
  parameter int MAX_EXP = 24,
  parameter int CNT_W   = 16,
  parameter int BACKOFF = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [EXP_W-1:0] cfg_init_exp,
  input  logic [CNT_W-1:0]        cfg_grow_steps,
  input  logic                    grad_valid,
  input  logic                    grad_last,
  input  logic [15:0]             grad_data,
  output logic                    step_done,
  output logic                    step_skip,
  output logic signed [EXP_W-1:0] scale_exp,
  input  logic [15:0]             unscale_in,
  output logic [15:0]             unscale_out,
  output logic                    unscale_ovf
);
  localparam int T_W = EXP_W + 4;
  localparam logic signed [EXP_W-1:0] EMIN = EXP_W'(MIN_EXP);
  localparam logic signed [EXP_W-1:0] EMAX = EXP_W'(MAX_EXP);

  logic             ovf_acc;
  logic [CNT_W-1:0] clean_cnt;

  wire word_bad = grad_valid && (&grad_data[14:10]);
  wire step_end = grad_valid && grad_last;
  wire step_ovf = ovf_acc || word_bad;
  wire grow_now = ({1'b0, clean_cnt} + 1'b1) >= {1'b0, cfg_grow_steps};
  wire unused_bits = ^{grad_data[15], grad_data[9:0]};

  wire signed [EXP_W:0] exp_dn = {scale_exp[EXP_W-1], scale_exp} - (EXP_W+1)'(BACKOFF);
  wire signed [EXP_W-1:0] exp_dn_sat =
    (exp_dn < (EXP_W+1)'(MIN_EXP)) ? EMIN : exp_dn[EXP_W-1:0];
  wire signed [EXP_W-1:0] exp_up_sat =
    (scale_exp >= EMAX) ? EMAX : scale_exp + EXP_W'(1);
  wire signed [EXP_W-1:0] init_sat =
    (cfg_init_exp < EMIN) ? EMIN : (cfg_init_exp > EMAX) ? EMAX : cfg_init_exp;

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_exp <= init_sat;
      clean_cnt <= '0;
      ovf_acc   <= 1'b0;
      step_done <= 1'b0;
      step_skip <= 1'b0;
    end else begin
      step_done <= step_end;
      step_skip <= step_end && step_ovf;
      if (step_end) begin
        ovf_acc   <= 1'b0;
        clean_cnt <= '0;
        if (step_ovf)
          scale_exp <= exp_dn_sat;
        else if (grow_now)
          scale_exp <= exp_up_sat;
        else
          clean_cnt <= clean_cnt + 1'b1;
      end else if (word_bad) begin
        ovf_acc <= 1'b1;
      end
    end
  end

  logic                  u_sgn;
  logic [4:0]            u_e;
  logic [10:0]           u_sig, u_norm;
  logic [3:0]            u_lz;
  logic signed [T_W-1:0] u_t;
  logic [T_W-1:0]        u_rsh;

  always_comb begin
    u_sgn = unscale_in[15];
    u_e   = unscale_in[14:10];
    u_sig = {u_e != 5'd0, unscale_in[9:0]};
    u_lz  = 4'd11;
    for (int i = 0; i < 11; i++)
      if (u_sig[i]) u_lz = 4'(10 - i);
    u_norm = u_sig << u_lz;
    u_t    = T_W'($signed({1'b0, (u_e == 5'd0) ? 5'd1 : u_e}))
           - T_W'($signed({1'b0, u_lz}))
           - T_W'(scale_exp);
    u_rsh  = T_W'(1) - u_t;
    unscale_ovf = 1'b0;
    if (&u_e)
      unscale_out = unscale_in;
    else if (u_sig == 11'd0)
      unscale_out = {u_sgn, 15'd0};
    else if (u_t >= T_W'(31)) begin
      unscale_out = {u_sgn, 5'h1f, 10'd0};
      unscale_ovf = 1'b1;
    end else if (u_t >= T_W'(1))
      unscale_out = {u_sgn, u_t[4:0], u_norm[9:0]};
    else if (u_rsh >= T_W'(11))
      unscale_out = {u_sgn, 15'd0};
    else
      unscale_out = {u_sgn, 5'd0, u_norm[10:1] >> (u_rsh - 1'b1)};
  end
endmodule

// File: rtl/loss_scale_ctrl_chk.sv
module loss_scale_ctrl_chk #(
  parameter int EXP_W   = 6,
  parameter int MIN_EXP = 0,
  parameter int MAX_EXP = 24,
  parameter int BACKOFF = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    grad_valid,
  input logic                    grad_last,
  input logic [15:0]             grad_data,
  input logic                    step_done,
  input logic                    step_skip,
  input logic signed [EXP_W-1:0] scale_exp,
  input logic [15:0]             unscale_in,
  input logic [15:0]             unscale_out,
  input logic                    unscale_ovf
);
  wire unused_chk = ^{grad_data[15], grad_data[9:0]};

  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    step_done |-> $past(grad_valid && grad_last));

  assert_skip_with_done_R3: assert property (@(posedge clk) disable iff (rst)
    step_skip |-> step_done);

  assert_clean_last_word_R2: assert property (@(posedge clk) disable iff (rst)
    (step_done && !step_skip) |-> !$past(grad_valid && (&grad_data[14:10])));

  assert_exp_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (int'(scale_exp) >= MIN_EXP) && (int'(scale_exp) <= MAX_EXP));

  assert_exp_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!step_done && !$past(rst)) |-> $stable(scale_exp));

  assert_backoff_R4: assert property (@(posedge clk) disable iff (rst)
    (step_done && step_skip) |->
      int'(scale_exp) == ((int'($past(scale_exp)) - BACKOFF < MIN_EXP)
                          ? MIN_EXP : int'($past(scale_exp)) - BACKOFF));

  assert_clean_no_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (step_done && !step_skip) |-> (int'(scale_exp) >= int'($past(scale_exp))));

  assert_passthru_R9: assert property (@(posedge clk) disable iff (rst)
    (&unscale_in[14:10]) |-> (unscale_out == unscale_in) && !unscale_ovf);

  assert_ovf_is_inf_R8: assert property (@(posedge clk) disable iff (rst)
    unscale_ovf |-> (unscale_out[14:0] == 15'h7c00) && (unscale_out[15] == unscale_in[15]));
endmodule

bind loss_scale_ctrl loss_scale_ctrl_chk #(
  .EXP_W(EXP_W), .MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP), .BACKOFF(BACKOFF)
) u_chk (.*);

// File: tb/loss_scale_ctrl_test.sv
module loss_scale_ctrl_test;
  localparam int EXP_W = 6, MIN_EXP = -4, MAX_EXP = 12, CNT_W = 4, BACKOFF = 1;

  logic clk = 1'b0;
  logic rst;
  logic signed [EXP_W-1:0] cfg_init_exp;
  logic [CNT_W-1:0] cfg_grow_steps;
  logic grad_valid, grad_last;
  logic [15:0] grad_data;
  logic step_done, step_skip;
  logic signed [EXP_W-1:0] scale_exp;
  logic [15:0] unscale_in, unscale_out;
  logic unscale_ovf;

  int checks = 0, failures = 0;
  int mexp, mcnt;
  bit finished = 0;

  always #10 clk = ~clk;

  loss_scale_ctrl #(.EXP_W(EXP_W), .MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP),
                    .CNT_W(CNT_W), .BACKOFF(BACKOFF)) uut (
    .clk(clk), .rst(rst), .cfg_init_exp(cfg_init_exp), .cfg_grow_steps(cfg_grow_steps),
    .grad_valid(grad_valid), .grad_last(grad_last), .grad_data(grad_data),
    .step_done(step_done), .step_skip(step_skip), .scale_exp(scale_exp),
    .unscale_in(unscale_in), .unscale_out(unscale_out), .unscale_ovf(unscale_ovf));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic real p2(input int k);
    real r;
    r = 1.0;
    if (k >= 0) repeat (k) r = r * 2.0;
    else repeat (-k) r = r / 2.0;
    return r;
  endfunction

  function automatic logic [16:0] ref_unscale(input logic [15:0] h, input int e);
    int ef, mf, k, mant;
    real m;
    ef = int'(h[14:10]);
    mf = int'(h[9:0]);
    if (ef == 31) return {1'b0, h};
    if (ef == 0) m = real'(mf) * p2(-24);
    else m = real'(1024 + mf) * p2(ef - 25);
    m = m * p2(-e);
    if (m == 0.0) return {1'b0, h[15], 15'd0};
    if (m > 65504.0) return {1'b1, h[15], 5'h1f, 10'd0};
    if (m >= p2(-14)) begin
      k = -14;
      while (m >= p2(k + 1)) k++;
      mant = $rtoi((m / p2(k) - 1.0) * 1024.0);
      return {1'b0, h[15], 5'(k + 15), 10'(mant)};
    end
    mant = $rtoi(m / p2(-24));
    return {1'b0, h[15], 5'd0, 10'(mant)};
  endfunction

  function automatic int clampi(input int v);
    if (v < MIN_EXP) return MIN_EXP;
    if (v > MAX_EXP) return MAX_EXP;
    return v;
  endfunction

  task automatic model_step(input bit ovf);
    int iv;
    iv = (cfg_grow_steps == 0) ? 1 : int'(cfg_grow_steps);
    if (ovf) begin
      mexp = clampi(mexp - BACKOFF);
      mcnt = 0;
    end else if (mcnt + 1 >= iv) begin
      mexp = clampi(mexp + 1);
      mcnt = 0;
    end else mcnt++;
  endtask

  task automatic apply_reset(input int init, input int iv);
    @(negedge clk);
    rst = 1'b1;
    grad_valid = 1'b0; grad_last = 1'b0; grad_data = 16'h0;
    cfg_init_exp = EXP_W'(init);
    cfg_grow_steps = CNT_W'(iv);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mexp = clampi(init);
    mcnt = 0;
    chk(int'(scale_exp) == mexp, "R1 reset scale", int'(scale_exp), mexp);
    chk(step_done == 1'b0, "R1 reset done", int'(step_done), 0);
    chk(step_skip == 1'b0, "R1 reset skip", int'(step_skip), 0);
  endtask

  task automatic end_check(input bit ovf);
    model_step(ovf);
    chk(step_done == 1'b1, "R3 done pulse", int'(step_done), 1);
    chk(step_skip == ovf, "R2 skip decision", int'(step_skip), int'(ovf));
    chk(int'(scale_exp) == mexp, ovf ? "R4 backoff" : "R5 growth", int'(scale_exp), mexp);
    grad_valid = 1'b0; grad_last = 1'b0; grad_data = 16'h0;
    @(negedge clk);
    chk(step_done == 1'b0, "R3 single pulse", int'(step_done), 0);
    chk(step_skip == 1'b0, "R3 skip idle", int'(step_skip), 0);
    chk(int'(scale_exp) == mexp, "R6 hold idle", int'(scale_exp), mexp);
  endtask

  function automatic logic [15:0] clean_word(input int i);
    case (i % 4)
      0: return 16'h3c00;
      1: return 16'h7bff;
      2: return 16'h0001;
      default: return 16'h8400 + 16'(i);
    endcase
  endfunction

  task automatic do_step(input int n, input int bad_at, input bit gap_bad);
    bit ovf;
    ovf = 0;
    for (int i = 0; i < n; i++) begin
      if (gap_bad && i > 0) begin
        grad_valid = 1'b0; grad_last = 1'b1; grad_data = 16'h7e00;
        @(negedge clk);
        chk(step_done == 1'b0, "R2 invalid word ignored", int'(step_done), 0);
      end
      grad_valid = 1'b1;
      grad_last = (i == n - 1);
      if (i == bad_at) begin
        grad_data = (i % 2 == 1) ? 16'hfc00 : 16'h7e01;
        ovf = 1;
      end else grad_data = clean_word(i);
      @(negedge clk);
      if (i < n - 1) begin
        chk(int'(scale_exp) == mexp, "R6 hold mid step", int'(scale_exp), mexp);
        chk(step_done == 1'b0, "R3 no early done", int'(step_done), 0);
      end
    end
    end_check(ovf);
  endtask

  task automatic one_word(input logic [15:0] w);
    grad_valid = 1'b1; grad_last = 1'b1; grad_data = w;
    @(negedge clk);
    end_check(&w[14:10]);
  endtask

  task automatic sweep_unscale(input int e);
    logic [16:0] r;
    string tag;
    apply_reset(e, 15);
    for (int w = 0; w < 65536; w++) begin
      unscale_in = 16'(w);
      #1;
      r = ref_unscale(16'(w), e);
      if (&unscale_in[14:10]) tag = "R9 passthru";
      else if (r[16]) tag = "R8 overflow";
      else if (r[14:0] == 15'd0 && unscale_in[14:0] != 15'd0) tag = "R10 flush";
      else tag = "R7 unscale";
      chk({unscale_ovf, unscale_out} == r, tag, int'({unscale_ovf, unscale_out}), int'(r));
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    unscale_in = 16'h0;
    cfg_init_exp = '0; cfg_grow_steps = '0;
    grad_valid = 1'b0; grad_last = 1'b0; grad_data = 16'h0;

    apply_reset(3, 3);
    for (int k = 0; k < 7; k++) do_step(1 + k % 4, -1, 0);
    do_step(4, 1, 0);
    do_step(3, 2, 0);
    do_step(3, -1, 1);
    do_step(2, -1, 0);
    do_step(1, 0, 0);
    do_step(2, -1, 0);
    do_step(1, -1, 0);
    do_step(1, -1, 0);
    do_step(3, 0, 1);

    cfg_grow_steps = '0;
    for (int k = 0; k < 14; k++) do_step(1 + k % 2, -1, 0);
    cfg_grow_steps = 4'd15;
    for (int k = 0; k < 20; k++) do_step(2, k % 2, 0);
    for (int k = 0; k < 16; k++) do_step(1, -1, 0);

    for (int e = 0; e < 32; e++) one_word({e[0], 5'(e), 10'(e * 37)});

    apply_reset(30, 3);
    apply_reset(-20, 3);

    sweep_unscale(-4);
    sweep_unscale(0);
    sweep_unscale(1);
    sweep_unscale(7);
    sweep_unscale(12);

    finished = 1;
    finish_run();
  end
endmodule